// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Threshold and Idle Timeout

This block holds the bytes a serial receiver has assembled until host software reads them. In queue mode it stores up to sixteen bytes in arrival order, reports its occupancy, and raises a trigger flag once the occupancy reaches a threshold. The threshold is chosen through a control byte. An idle detector marks a timeout when bytes remain queued and nothing has been received or read for four character times. The character time is counted in bit-time strobes and derived from the current line format. With the queue disabled, the block falls back to a single holding byte.

The block also keeps the receive status bits: data ready, overrun and break. Reading the line status through a dedicated strobe clears overrun and break. A write to the control byte can flush the receive queue and request a flush of the transmit queue. Any write that flips the enable bit flushes both. The serial shifter and the host register decoder sit outside the block.

Top module: `uart_rxq`

## Requirements
- R1: In queue mode, bytes are read back in arrival order. `level` reports the occupancy (0 to DEPTH). `rd_data` shows the oldest byte, or 0 when the queue is empty.
- R2: A byte that arrives while the queue holds DEPTH bytes, with no read in the same cycle, is dropped. The stored bytes and `level` stay unchanged and `overrun` is set.
- R3: Control bits 7:6 select the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queue mode `trig_hit` equals `data_ready` AND (`level` >= threshold). In holding mode `trig_hit` equals `data_ready`.
- R4: A control write with bit 1 set flushes the receive queue, clearing `level`, `data_ready`, `brk_seen` and `timeout_pend`. Bit 2 pulses `tx_flush` in the write cycle. Bit 0 enables queue mode. A write that flips bit 0 does both flushes. Only bits 7, 6, 3 and 0 are kept and read back on `fifo_ctl`. A write equal to the current `fifo_ctl` value has no effect.
- R5: In queue mode with `level` non-zero, `timeout_pend` rises after exactly 4 × frame `baud_tick` strobes with no byte received and no read. Any received byte restarts the count.
- R6: The frame length in bits is 1 + (line_ctl[1:0] + 5) + line_ctl[3] + (line_ctl[2] ? 2 : 1).
- R7: A read clears `timeout_pend`. If the read empties the queue, `data_ready` and `brk_seen` clear. Otherwise the idle count restarts from zero.
- R8: A break indication stores a zero byte and sets both `brk_seen` and `data_ready`.
- R9: In holding mode, a byte that arrives while `data_ready` is set without a read in the same cycle sets `overrun` and replaces the held byte. A read clears `data_ready`.
- R10: `stat_rd` clears `overrun` and `brk_seen` unless a new overrun or break arrives in the same cycle.
- R11: After reset, `fifo_ctl`, `level`, `data_ready`, `overrun`, `brk_seen`, `trig_hit` and `timeout_pend` are all 0.
- R12: In a cycle where a control write flushes the receive queue, a byte arriving and a read strobe in that same cycle are both ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | A break condition was received (stores a zero byte) |
| rd_strobe | input | 1 | Host reads one byte |
| stat_rd | input | 1 | Host reads line status (clears overrun and break) |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| line_ctl | input | 4 | Line format: [1:0] data length code, [2] two stop bits, [3] parity on |
| baud_tick | input | 1 | One strobe per bit time |
| rd_data | output | 8 | Oldest byte (queue mode) or holding byte |
| data_ready | output | 1 | Received data is available |
| overrun | output | 1 | A byte was lost |
| brk_seen | output | 1 | A break was received |
| level | output | $clog2(DEPTH+1) | Queue occupancy |
| trig_hit | output | 1 | Data ready and occupancy at or above the threshold |
| timeout_pend | output | 1 | Idle timeout pending |
| fifo_ctl | output | 8 | Kept control bits |
| tx_flush | output | 1 | Transmit queue flush request (same cycle as the write) |

## Verification
The bench uses the default DEPTH of 16 and TMO_CHARS of 4. The 14-byte threshold is then two bytes below full, so one fill covers the trigger edge, the full queue and an overrun. The idle limits of 36 and 40 ticks are short enough to count out the exact strobe on which the timeout rises. A seeded random phase of pushes and reads drives the queue across empty and full many times and compares it against a queue model.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;

    localparam int BYTE_W    = 8;
    localparam int FRAME_MAX = 12;

    // control byte bit positions that the decode depends on
    localparam int CB_EN   = 0;
    localparam int CB_RXR  = 1;
    localparam int CB_TXR  = 2;
    localparam int CB_DMA  = 3;

    typedef struct packed {
        logic [1:0] trig_sel;
        logic       dma_sel;
        logic       enable;
    } rxq_mode_t;

    // bits of one serial frame for a given line format
    function automatic logic [3:0] frame_bits(input logic [3:0] lc);
        logic [3:0] b;
        b = 4'd6 + {2'b00, lc[1:0]};
        b = b + {3'b000, lc[3]};
        b = b + (lc[2] ? 4'd2 : 4'd1);
        return b;
    endfunction

    function automatic logic [3:0] trig_bytes(input logic [1:0] sel);
        logic [3:0] t;
        case (sel)
            2'b00:   t = 4'd1;
            2'b01:   t = 4'd4;
            2'b10:   t = 4'd8;
            default: t = 4'd14;
        endcase
        return t;
    endfunction

    function automatic logic [7:0] mode_to_byte(input rxq_mode_t m);
        return {m.trig_sel, 2'b00, m.dma_sel, 2'b00, m.enable};
    endfunction

endpackage

// File: rtl/uart_rxq_ctl.sv
`timescale 1ns/1ps
module uart_rxq_ctl
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output rxq_mode_t  mode,
    output logic       rx_flush,
    output logic       tx_flush
);
    logic changed;
    logic en_flip;

    assign changed  = we && (wdata != mode_to_byte(mode));
    assign en_flip  = wdata[CB_EN] != mode.enable;
    assign rx_flush = changed && (wdata[CB_RXR] || en_flip);
    assign tx_flush = changed && (wdata[CB_TXR] || en_flip);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (changed) begin
            mode.trig_sel <= wdata[7:6];
            mode.dma_sel  <= wdata[CB_DMA];
            mode.enable   <= wdata[CB_EN];
        end
    end
endmodule

// File: rtl/uart_rxq_store.sv
`timescale 1ns/1ps
module uart_rxq_store #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head_data,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = level == LVL_W'(DEPTH);
    assign do_pop    = pop && (level != '0);
    assign do_push   = push && (!full || do_pop);
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + LVL_W'(1);
            else if (do_pop && !do_push) level <= level - LVL_W'(1);
        end
    end
endmodule

// File: rtl/uart_rxq_timer.sv
`timescale 1ns/1ps
module uart_rxq_timer
    import uart_rxq_pkg::*;
#(
    parameter int TMO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic       clear,
    input  logic       tick,
    input  logic [3:0] frame,
    output logic       pend
);
    localparam int LIM_MAX = TMO_CHARS * FRAME_MAX;
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          hit;

    assign limit = CW'(TMO_CHARS) * CW'(frame);
    assign hit   = run && tick && !pend && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (restart || !run)  cnt <= '0;
            else if (tick && !pend) cnt <= cnt + CW'(1);

            if (clear)                 pend <= 1'b0;
            else if (hit && !restart)  pend <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rxq.sv
`timescale 1ns/1ps
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_break,
    input  logic             rd_strobe,
    input  logic             stat_rd,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic [3:0]       line_ctl,
    input  logic             baud_tick,
    output logic [7:0]       rd_data,
    output logic             data_ready,
    output logic             overrun,
    output logic             brk_seen,
    output logic [LVL_W-1:0] level,
    output logic             trig_hit,
    output logic             timeout_pend,
    output logic [7:0]       fifo_ctl,
    output logic             tx_flush
);
    rxq_mode_t  mode;
    logic       rx_flush, fifo_on;
    logic       acc_push, acc_pop, full, empties, ovr_set;
    logic [7:0] in_byte, head_data, hold_q;

    uart_rxq_ctl u_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
        .mode(mode), .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    assign fifo_on  = mode.enable;
    assign in_byte  = rx_break ? 8'h00 : rx_data;
    assign acc_push = (rx_valid || rx_break) && !rx_flush;
    assign acc_pop  = rd_strobe && !rx_flush;

    uart_rxq_store #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(fifo_on && acc_push), .push_data(in_byte),
        .pop(fifo_on && acc_pop), .head_data(head_data), .level(level)
    );

    uart_rxq_timer #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk(clk), .rst(rst),
        .run(fifo_on && (level != '0)),
        .restart((fifo_on && (acc_push || acc_pop)) || rx_flush),
        .clear((fifo_on && acc_pop) || rx_flush),
        .tick(baud_tick), .frame(frame_bits(line_ctl)),
        .pend(timeout_pend)
    );

    assign full    = level == LVL_W'(DEPTH);
    assign empties = fifo_on ? (level <= LVL_W'(1)) : 1'b1;
    assign ovr_set = acc_push && !acc_pop && (fifo_on ? full : data_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_ready <= 1'b0;
            brk_seen   <= 1'b0;
            overrun    <= 1'b0;
            hold_q     <= '0;
        end else begin
            if (rx_flush)                data_ready <= 1'b0;
            else if (acc_push)           data_ready <= 1'b1;
            else if (acc_pop && empties) data_ready <= 1'b0;

            if (rx_flush)                     brk_seen <= 1'b0;
            else if (acc_push && rx_break)    brk_seen <= 1'b1;
            else if (stat_rd)                 brk_seen <= 1'b0;
            else if (acc_pop && empties)      brk_seen <= 1'b0;

            if (ovr_set)      overrun <= 1'b1;
            else if (stat_rd) overrun <= 1'b0;

            if (!fifo_on && acc_push) hold_q <= in_byte;
        end
    end

    always_comb begin
        if (!fifo_on)          rd_data = hold_q;
        else if (level != '0)  rd_data = head_data;
        else                   rd_data = 8'h00;
    end

    assign trig_hit = data_ready &&
                      (!fifo_on || (level >= LVL_W'(trig_bytes(mode.trig_sel))));
    assign fifo_ctl = mode_to_byte(mode);
endmodule

// File: rtl/uart_rxq_chk.sv
`timescale 1ns/1ps
module uart_rxq_chk #(
    parameter int DEPTH     = 16,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_break,
    input logic             rd_strobe,
    input logic             stat_rd,
    input logic             ctl_we,
    input logic [7:0]       ctl_wdata,
    input logic [LVL_W-1:0] level,
    input logic             data_ready,
    input logic             overrun,
    input logic             brk_seen,
    input logic             timeout_pend,
    input logic [7:0]       fifo_ctl
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_overrun_keep_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_ctl[0] && level == LVL_W'(DEPTH) && rx_valid && !rd_strobe && !ctl_we
        |=> overrun && level == LVL_W'(DEPTH));

    assert_rx_reset_R4: assert property (@(posedge clk) disable iff (rst)
        ctl_we && ctl_wdata[1] && ctl_wdata != fifo_ctl
        |=> level == '0 && !timeout_pend && !data_ready);

    assert_tmo_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        timeout_pend |-> fifo_ctl[0] && level != '0);

    assert_read_clears_tmo_R7: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && fifo_ctl[0] && !ctl_we |=> !timeout_pend);

    assert_break_flags_R8: assert property (@(posedge clk) disable iff (rst)
        rx_break && !ctl_we |=> brk_seen && data_ready);

    assert_holding_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        !fifo_ctl[0] && data_ready && rx_valid && !rd_strobe && !ctl_we |=> overrun);

    assert_status_clear_R10: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !rx_valid && !rx_break |=> !overrun && !brk_seen);
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/uart_rxq_tb.sv
`timescale 1ns/1ps
module uart_rxq_tb_top;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_break = 0, rd_strobe = 0, stat_rd = 0, ctl_we = 0, baud_tick = 0;
    logic [7:0] rx_data = 0, ctl_wdata = 0;
    logic [3:0] line_ctl = 4'b0011;
    logic [7:0] rd_data, fifo_ctl;
    logic data_ready, overrun, brk_seen, trig_hit, timeout_pend, tx_flush;
    logic [LVL_W-1:0] level;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] q[$];

    always #2 clk = ~clk;

    uart_rxq #(.DEPTH(DEPTH), .TMO_CHARS(4)) dut_i (.*);

    function automatic int frame_len(input int lc);
        return 1 + (lc & 3) + 5 + ((lc >> 3) & 1) + (((lc >> 2) & 1) ? 2 : 1);
    endfunction

    function automatic int thr_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_data = b; step(); rx_valid = 0;
    endtask

    task automatic pop_chk(input string req, input int exp);
        chk(req, rd_data, exp);
        rd_strobe = 1; step(); rd_strobe = 0;
    endtask

    task automatic wctl(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; step(); ctl_we = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1; step(); baud_tick = 0;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int lim;
        void'($urandom(32'h5eed_1234));
        step(); step(); step();
        rst = 0;
        step();
        // R11 reset state
        chk("R11 fifo_ctl", fifo_ctl, 0);
        chk("R11 level", level, 0);
        chk("R11 data_ready", data_ready, 0);
        chk("R11 overrun", overrun, 0);
        chk("R11 trig/tmo", {trig_hit, timeout_pend, brk_seen}, 0);

        // R4 enable flip pulses tx_flush; mask of kept bits
        ctl_we = 1; ctl_wdata = 8'h01; #1;
        chk("R4 tx_flush on enable flip", tx_flush, 1);
        step(); ctl_we = 0;
        chk("R4 enable kept", fifo_ctl, 8'h01);
        wctl(8'hFF);
        chk("R4 kept bits mask", fifo_ctl, 8'hC9);

        // R3/R2/R1 fill to full at threshold 14
        q.delete();
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] b = 8'($urandom);
            push(b); q.push_back(b);
            if (i == 12) chk("R3 below 14", trig_hit, 0);
            if (i == 13) chk("R3 at 14", trig_hit, 1);
        end
        chk("R1 level full", level, DEPTH);
        push(8'hEE);
        chk("R2 overrun set", overrun, 1);
        chk("R2 level kept", level, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_chk("R1/R2 order", q[i]);
        chk("R7 empty clears ready", data_ready, 0);
        chk("R1 empty rd_data", rd_data, 0);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R10 overrun cleared", overrun, 0);

        // R3 every threshold code
        for (int c = 0; c < 4; c++) begin
            wctl(8'((c << 6) | 3));
            chk("R4 flush level", level, 0);
            for (int k = 0; k < thr_of(c) - 1; k++) push(8'(k));
            chk("R3 below threshold", trig_hit, 0);
            push(8'h11);
            chk("R3 threshold reached", trig_hit, 1);
        end
        // R4 equal write ignored, then flush
        wctl(8'hC1);
        chk("R4 equal write no flush", level, 14);
        wctl(8'hC3);
        chk("R4 rx reset level", level, 0);
        chk("R4 rx reset ready", data_ready, 0);

        // R5/R6/R7 timeout with two line formats
        for (int f = 0; f < 2; f++) begin
            line_ctl = (f == 0) ? 4'b0011 : 4'b1100;
            lim = 4 * frame_len(line_ctl);
            push(8'h21);
            ticks(20);
            push(8'h22);
            ticks(lim - 1);
            chk("R5/R6 not yet pending", timeout_pend, 0);
            ticks(1);
            chk("R5/R6 pending at limit", timeout_pend, 1);
            pop_chk("R7 read first", 8'h21);
            chk("R7 read clears pend", timeout_pend, 0);
            chk("R7 ready stays", data_ready, 1);
            ticks(lim - 1);
            chk("R7 restart not pending", timeout_pend, 0);
            ticks(1);
            chk("R7 restart pending", timeout_pend, 1);
            pop_chk("R7 read last", 8'h22);
            chk("R7 empty clears pend", timeout_pend, 0);
        end

        // R8 break in queue mode
        push(8'h55);
        rx_break = 1; step(); rx_break = 0;
        chk("R8 break level", level, 2);
        chk("R8 break flags", {brk_seen, data_ready}, 2'b11);
        pop_chk("R8 first byte", 8'h55);
        pop_chk("R8 zero byte", 8'h00);
        chk("R7 empty clears break", brk_seen, 0);

        // R12 flush drops same-cycle push
        push(8'h66);
        ctl_we = 1; ctl_wdata = 8'hC3; rx_valid = 1; rx_data = 8'h77; step();
        ctl_we = 0; rx_valid = 0;
        chk("R12 same-cycle push dropped", level, 0);

        // R9 holding mode
        wctl(8'h00);
        chk("R4 disable", fifo_ctl, 0);
        push(8'hA1);
        chk("R9 holding byte", rd_data, 8'hA1);
        chk("R3 holding trig", trig_hit, 1);
        chk("R9 level stays 0", level, 0);
        push(8'hB2);
        chk("R9 overrun", overrun, 1);
        chk("R9 replaced", rd_data, 8'hB2);
        rd_strobe = 1; step(); rd_strobe = 0;
        chk("R9 read clears ready", data_ready, 0);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R10 clear", overrun, 0);

        // R1/R2 random traffic against a queue model
        wctl(8'h01);
        q.delete();
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 100);
            logic do_p = (r < 55);
            logic do_r = ((r % 3) == 0);
            logic [7:0] b = 8'($urandom);
            if (do_r) chk("R1 random head", rd_data, (q.size() > 0) ? q[0] : 0);
            rx_valid = do_p; rx_data = b; rd_strobe = do_r;
            step();
            rx_valid = 0; rd_strobe = 0;
            if (do_r && q.size() > 0) void'(q.pop_front());
            if (do_p && q.size() < DEPTH) q.push_back(b);
            chk("R1/R2 random level", level, q.size());
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule